// File: doc/BRIEF.md
# Three-Share Masked Ripple-Carry Adder

This block adds two operands and a carry-in that arrive split into three Boolean shares each. The real value of any signal is the XOR of its three shares. The block produces a three-share sum and a three-share carry-out. No share combination inside the block ever rebuilds a real operand bit, so the block can sit in a protected datapath that resists first-order observation. The arithmetic datapath of a masked ALU would use it, with one register stage separating it from the logic around it.

Each sum bit is the XOR of three values: the two operand bits and the incoming carry. The block computes it share by share, so it needs no fresh randomness. The carry into the next position is the three-input majority function. It is split by direct sharing into three component functions, and component k never reads share k of its inputs. Eight such cells form a ripple chain. The carry-out shares of the top position leave the block as the shared carry flag. All outputs are registered, so results appear one clock after the inputs are applied.

Top module: `masked_ripple_adder`

## Requirements
- R1: One clock edge after inputs are applied, the XOR of the three sum-share outputs equals bits WIDTH-1..0 of A+B+Cin. Here A, B and Cin are the XORs of the three shares of each input.
- R2: One clock edge after inputs are applied, the XOR of the three carry-out shares equals bit WIDTH of A+B+Cin.
- R3: Bit 0 of sum share k equals bit 0 of operand-A share k, XOR bit 0 of operand-B share k, XOR carry-in share k. This holds for each k in 0..2.
- R4: Bit 1 of sum share k does not depend on share k of the bit-0 inputs: bit 0 of A share k, bit 0 of B share k and carry-in share k. Changing only those three bits leaves that output bit unchanged.
- R5: While rst_n is low, every sum share and every carry-out share reads zero at the following clock edge.
- R6: A carry generated at bit 0 ripples through every position. A=all-ones with B=0 and Cin=1 gives sum 0 and carry-out 1. A=all-ones with B=1 and Cin=0 gives the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a_sh | input | 3×WIDTH | Operand A, one WIDTH-bit vector per share |
| op_b_sh | input | 3×WIDTH | Operand B, one WIDTH-bit vector per share |
| cin_sh | input | 3 | Carry-in, one bit per share |
| sum_sh | output | 3×WIDTH | Registered sum, one WIDTH-bit vector per share |
| cout_sh | output | 3 | Registered carry-out, one bit per share |

## Verification
The bench sweeps every combination of A, B and Cin for the 8-bit configuration. Each vector gets fresh random masks, so many different sharings of the same values are exercised. Wrong carries and broken recombination both show up in this sweep. Separate vectors target full carry propagation and the reset value. A further test randomizes only share k of the bit-0 inputs and confirms that bit 1 of sum share k stays the same. That test catches a carry component that reads its own share index.

// File: rtl/masked_add_pkg.sv
// Package: shared constants and component-function helpers for the
// three-share masked adder. Assumes Boolean (XOR) sharing.
package masked_add_pkg;

    // Number of shares; three is the minimum for first-order protection.
    localparam int unsigned SHARES = 3;

    // Component of a shared AND that omits one share index. Inputs are the
    // two remaining shares (p, q) of each operand.
    function automatic logic and_part(input logic xp, input logic xq,
                                      input logic yp, input logic yq);
        return (xp & yp) ^ (xp & yq) ^ (xq & yp);
    endfunction

endpackage

// File: rtl/ms_share_sum.sv
// Module: share-wise sum bit. Each output share is the XOR of the matching
// input shares; XOR is linear, so a uniform input sharing stays uniform.
module ms_share_sum
    import masked_add_pkg::*;
(
    input  logic [SHARES-1:0] x_sh,
    input  logic [SHARES-1:0] y_sh,
    input  logic [SHARES-1:0] c_sh,
    output logic [SHARES-1:0] s_sh
);

    // Purpose: XOR the three operands within each share.
    always_comb begin
        s_sh = x_sh ^ y_sh ^ c_sh;
    end

endmodule

// File: rtl/ms_share_maj.sv
// Module: directly shared three-input majority. Output share k is built only
// from input shares other than k (non-completeness). The three outputs XOR
// to maj(x,y,c). Assumes three shares; no randomness is added.
module ms_share_maj
    import masked_add_pkg::*;
(
    input  logic [SHARES-1:0] x_sh,
    input  logic [SHARES-1:0] y_sh,
    input  logic [SHARES-1:0] c_sh,
    output logic [SHARES-1:0] m_sh
);

    for (genvar k = 0; k < SHARES; k++) begin : g_comp
        localparam int P = (k + 1) % SHARES;
        localparam int Q = (k + 2) % SHARES;

        // Purpose: component k, the XOR of the three pairwise AND components.
        always_comb begin
            m_sh[k] = and_part(x_sh[P], x_sh[Q], y_sh[P], y_sh[Q])
                    ^ and_part(x_sh[P], x_sh[Q], c_sh[P], c_sh[Q])
                    ^ and_part(y_sh[P], y_sh[Q], c_sh[P], c_sh[Q]);
        end
    end

endmodule

// File: rtl/ms_full_adder_cell.sv
// Module: one shared full-adder position. The sum goes through share-wise
// XOR; the carry goes through the direct majority sharing.
module ms_full_adder_cell
    import masked_add_pkg::*;
(
    input  logic [SHARES-1:0] a_sh,
    input  logic [SHARES-1:0] b_sh,
    input  logic [SHARES-1:0] ci_sh,
    output logic [SHARES-1:0] s_sh,
    output logic [SHARES-1:0] co_sh
);

    ms_share_sum u_sum (
        .x_sh (a_sh),
        .y_sh (b_sh),
        .c_sh (ci_sh),
        .s_sh (s_sh)
    );

    ms_share_maj u_maj (
        .x_sh (a_sh),
        .y_sh (b_sh),
        .c_sh (ci_sh),
        .m_sh (co_sh)
    );

endmodule

// File: rtl/masked_ripple_adder.sv
// Module: WIDTH-bit three-share ripple-carry adder with registered outputs.
// Assumes every input arrives uniformly shared. Latency is one clock.
// Synchronous active-low reset clears all output shares.
module masked_ripple_adder
    import masked_add_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [SHARES-1:0][WIDTH-1:0]  op_a_sh,
    input  logic [SHARES-1:0][WIDTH-1:0]  op_b_sh,
    input  logic [SHARES-1:0]             cin_sh,
    output logic [SHARES-1:0][WIDTH-1:0]  sum_sh,
    output logic [SHARES-1:0]             cout_sh
);

    localparam int unsigned CHAIN = WIDTH + 1;

    logic [CHAIN-1:0][SHARES-1:0]  carry_sh;
    logic [WIDTH-1:0][SHARES-1:0]  bit_sum_sh;
    logic [SHARES-1:0][WIDTH-1:0]  sum_next;

    assign carry_sh[0] = cin_sh;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [SHARES-1:0] a_bit;
        logic [SHARES-1:0] b_bit;

        for (genvar k = 0; k < SHARES; k++) begin : g_pick
            assign a_bit[k]       = op_a_sh[k][i];
            assign b_bit[k]       = op_b_sh[k][i];
            assign sum_next[k][i] = bit_sum_sh[i][k];
        end

        ms_full_adder_cell u_cell (
            .a_sh  (a_bit),
            .b_sh  (b_bit),
            .ci_sh (carry_sh[i]),
            .s_sh  (bit_sum_sh[i]),
            .co_sh (carry_sh[i+1])
        );
    end

    // Purpose: register the shared sum and carry-out, isolating this stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sum_sh  <= '0;
            cout_sh <= '0;
        end else begin
            sum_sh  <= sum_next;
            cout_sh <= carry_sh[CHAIN-1];
        end
    end

endmodule

// File: rtl/masked_ripple_adder_chk.sv
// Module: property checker for the masked adder, bound to the top module.
// It recombines the shares only for checking.
module masked_ripple_adder_chk
    import masked_add_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [SHARES-1:0][WIDTH-1:0]  op_a_sh,
    input  logic [SHARES-1:0][WIDTH-1:0]  op_b_sh,
    input  logic [SHARES-1:0]             cin_sh,
    input  logic [SHARES-1:0][WIDTH-1:0]  sum_sh,
    input  logic [SHARES-1:0]             cout_sh
);

    logic [WIDTH:0]   ref_total;
    logic [WIDTH-1:0] sum_plain;
    logic             cout_plain;

    // Purpose: arithmetic reference and recombined outputs.
    always_comb begin
        ref_total  = {1'b0, op_a_sh[0] ^ op_a_sh[1] ^ op_a_sh[2]}
                   + {1'b0, op_b_sh[0] ^ op_b_sh[1] ^ op_b_sh[2]}
                   + {{WIDTH{1'b0}}, ^cin_sh};
        sum_plain  = sum_sh[0] ^ sum_sh[1] ^ sum_sh[2];
        cout_plain = ^cout_sh;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (sum_sh == '0 && cout_sh == '0)); // R5

    AST_SUM_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> sum_plain == $past(ref_total[WIDTH-1:0])); // R1

    AST_CARRY_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> cout_plain == $past(ref_total[WIDTH])); // R2

    AST_LSB_SHAREWISE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ({sum_sh[2][0], sum_sh[1][0], sum_sh[0][0]} ==
            $past({op_a_sh[2][0], op_a_sh[1][0], op_a_sh[0][0]}
                ^ {op_b_sh[2][0], op_b_sh[1][0], op_b_sh[0][0]} ^ cin_sh))); // R3

endmodule

bind masked_ripple_adder masked_ripple_adder_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_a_sh (op_a_sh),
    .op_b_sh (op_b_sh),
    .cin_sh  (cin_sh),
    .sum_sh  (sum_sh),
    .cout_sh (cout_sh)
);

// File: tb/masked_ripple_adder_tb.sv
// Bench: exhaustive operand sweep with fresh random masks, plus reset,
// carry-propagation and share-independence checks.
module masked_ripple_adder_tb;

    localparam int W  = 8;
    localparam int NS = 3;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic [NS-1:0][W-1:0]    op_a_sh = '0;
    logic [NS-1:0][W-1:0]    op_b_sh = '0;
    logic [NS-1:0]           cin_sh = '0;
    logic [NS-1:0][W-1:0]    sum_sh;
    logic [NS-1:0]           cout_sh;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    masked_ripple_adder #(.WIDTH(W)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_a_sh (op_a_sh),
        .op_b_sh (op_b_sh),
        .cin_sh  (cin_sh),
        .sum_sh  (sum_sh),
        .cout_sh (cout_sh)
    );

    task automatic check(input bit ok, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    // Split plain values into fresh random shares and drive them.
    task automatic put(input logic [W-1:0] av, input logic [W-1:0] bv, input logic cv);
        logic [W-1:0] m0, m1;
        logic [1:0]   cm;
        m0 = W'($urandom); m1 = W'($urandom);
        op_a_sh[0] = m0; op_a_sh[1] = m1; op_a_sh[2] = av ^ m0 ^ m1;
        m0 = W'($urandom); m1 = W'($urandom);
        op_b_sh[0] = m0; op_b_sh[1] = m1; op_b_sh[2] = bv ^ m0 ^ m1;
        cm = 2'($urandom);
        cin_sh = {cv ^ cm[0] ^ cm[1], cm[1], cm[0]};
    endtask

    function automatic logic [W-1:0] sum_plain();
        return sum_sh[0] ^ sum_sh[1] ^ sum_sh[2];
    endfunction

    initial begin
        logic [NS-1:0][W-1:0] pa, pb;
        logic [NS-1:0]        pc;
        logic [W:0]           exp_t;
        logic                 base_bit;
        bit                   have;

        // R5: reset clears outputs even with nonzero inputs applied.
        put(8'hA5, 8'h3C, 1'b1);
        @(negedge clk); @(negedge clk);
        check(sum_sh == '0, "R5 sum shares in reset", 32'(sum_sh[0] | sum_sh[1] | sum_sh[2]), 32'h0);
        check(cout_sh == '0, "R5 carry shares in reset", 32'(cout_sh), 32'h0);
        rst_n = 1'b1;

        // R6: full carry propagation boundaries.
        put({W{1'b1}}, '0, 1'b1);
        @(negedge clk);
        check(sum_plain() == '0, "R6 all-ones+0+1 sum", 32'(sum_plain()), 32'h0);
        check(^cout_sh == 1'b1, "R6 all-ones+0+1 carry", 32'(^cout_sh), 32'h1);
        put({W{1'b1}}, W'(1), 1'b0);
        @(negedge clk);
        check(sum_plain() == '0, "R6 all-ones+1+0 sum", 32'(sum_plain()), 32'h0);
        check(^cout_sh == 1'b1, "R6 all-ones+1+0 carry", 32'(^cout_sh), 32'h1);

        // R4: bit 1 of sum share k ignores share k of the bit-0 inputs.
        for (int t = 0; t < 16; t++) begin
            put(W'($urandom), W'($urandom), 1'($urandom));
            pa = op_a_sh; pb = op_b_sh; pc = cin_sh;
            for (int k = 0; k < NS; k++) begin
                op_a_sh = pa; op_b_sh = pb; cin_sh = pc;
                @(negedge clk);
                base_bit = sum_sh[k][1];
                op_a_sh[k][0] = ~pa[k][0];
                op_b_sh[k][0] = 1'($urandom);
                cin_sh[k]     = 1'($urandom);
                @(negedge clk);
                check(sum_sh[k][1] == base_bit, $sformatf("R4 share %0d bit1 independence", k),
                      32'(sum_sh[k][1]), 32'(base_bit));
            end
        end

        // R1 R2 R3: exhaustive sweep of A, B, Cin, pipelined one per cycle.
        have = 1'b0;
        pa = '0; pb = '0; pc = '0;
        for (int v = 0; v <= (1 << (2*W+1)); v++) begin
            @(negedge clk);
            if (have) begin
                exp_t = {1'b0, pa[0]^pa[1]^pa[2]} + {1'b0, pb[0]^pb[1]^pb[2]} + (W+1)'(^pc);
                check(sum_plain() == exp_t[W-1:0], "R1 recombined sum",
                      32'(sum_plain()), 32'(exp_t[W-1:0]));
                check(^cout_sh == exp_t[W], "R2 recombined carry",
                      32'(^cout_sh), 32'(exp_t[W]));
                for (int k = 0; k < NS; k++)
                    check(sum_sh[k][0] == (pa[k][0] ^ pb[k][0] ^ pc[k]),
                          $sformatf("R3 share %0d bit0", k),
                          32'(sum_sh[k][0]), 32'(pa[k][0] ^ pb[k][0] ^ pc[k]));
            end
            if (v < (1 << (2*W+1))) begin
                put(W'(v), W'(v >> W), 1'(v >> (2*W)));
                pa = op_a_sh; pb = op_b_sh; pc = cin_sh;
                have = 1'b1;
            end
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule